// File: doc/BRIEF.md
# Counter Clock and Gate Router

This block steers the clock-enable and gate inputs of a group of three cascadable down-counters. It takes a 10 MHz base tick, presented as a one-cycle enable in the system clock domain. A chain of divide-by-ten stages turns that tick into slower enable pulses at 1 MHz, 100 kHz, 10 kHz and 1 kHz. Each counter can then be clocked from one of these rates, from an external clock pulse, or from a rising edge on a neighbouring counter's output.

Each counter's gate can be held on or held off. It can also follow an external gate level, or follow the inverted output of a different neighbour. The clock neighbours and the gate neighbours form two rings that run in opposite directions. Counters can therefore be chained into longer dividers or made to gate one another. For example, one counter running from the base rate can clock a second counter to make a slow pacing signal.

Software sets up the routing through two byte-wide write ports, one for clocks and one for gates. Each byte names a counter and a source code. The counters themselves sit outside this block, and their outputs come back in on `ctr_out`.

Top module: `ctr_clkgate_router`

## Requirements
- R1: After reset every counter selects the base-rate clock (`ctr_clk_en` equals `base_tick` on all three channels) and every gate is enabled (`ctr_gate` = 3'b111).
- R2: The prescaler counts `base_tick` pulses from reset. The 1 MHz enable is high in the cycle of every 10th base tick. Each further stage (100 kHz, 10 kHz, 1 kHz) is high on every 10th pulse of the stage before it, so those stages fire on base ticks 100, 1000 and 10000 and their multiples. Every such pulse lasts one cycle and falls in a cycle where `base_tick` is high.
- R3: In a configuration byte, bits 4:3 are the channel and bits 2:0 are the source code. Bits 7:5 are ignored. A write is sampled on the clock edge that ends the cycle in which its write enable is high. The new selection drives the outputs from the following cycle on.
- R4: Clock source codes:
  - 1 is the base tick.
  - 2, 3, 4 and 5 are the 1 MHz, 100 kHz, 10 kHz and 1 kHz enables.
  - 7 passes `ext_clk_pulse` straight through.
- R5: Clock source code 6 makes the clock enable a rising edge of a neighbour's output. Counter 0 follows counter 2, counter 1 follows counter 0, and counter 2 follows counter 1. The enable is high in a cycle where the neighbour's `ctr_out` bit is 1 and was 0 in the previous cycle. The bit counts as 0 in the cycle before reset ends.
- R6: Gate source codes:
  - 0 holds the gate high.
  - 1 holds it low.
  - 2 passes `ext_gate` through.
  - 3 uses the inverted output of a neighbour: counter 0 uses counter 1, counter 1 uses counter 2, and counter 2 uses counter 0.
- R7: A clock write with source code 0, a gate write with source code 4 to 7, and any write to channel 3 leave every selection unchanged.
- R8: A clock write and a gate write in the same cycle are both applied, including when both name the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle enable at the 10 MHz base rate |
| ext_clk_pulse | input | 1 | One-cycle enable from the external clock input |
| ext_gate | input | 1 | External gate level |
| clk_cfg_we | input | 1 | Clock selection write strobe |
| clk_cfg_byte | input | 8 | Clock selection byte (channel, source) |
| gate_cfg_we | input | 1 | Gate selection write strobe |
| gate_cfg_byte | input | 8 | Gate selection byte (channel, source) |
| ctr_out | input | 3 | Outputs of the three counters, fed back |
| ctr_clk_en | output | 3 | Per-counter clock enable |
| ctr_gate | output | 3 | Per-counter gate level |

## Verification
Clock selection and gate selection both update in the same cycle when both strobes are raised together. The bench does this on one channel and then on a different channel each time, and it checks in the next cycle that the clock enable and the gate level each show their own new source.

A channel's clock enable and a neighbour's ring feedback can also change on the same edge as a selection write. Each cycle's expectation is therefore taken from the selections in force before that edge. The expected values come from a model of the stated source codes and ring connections, which is independent of the design.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;

   // configuration byte layout
   localparam int CFG_W  = 8;
   localparam int SRC_W  = 3;
   localparam int CH_W   = 2;
   localparam int CH_LSB = SRC_W;
   // number of divide stages below the base rate
   localparam int NUM_DIV = 4;

   typedef enum logic [SRC_W-1:0] {
      CK_RSVD = 3'd0,
      CK_BASE = 3'd1,
      CK_DIV1 = 3'd2,
      CK_DIV2 = 3'd3,
      CK_DIV3 = 3'd4,
      CK_DIV4 = 3'd5,
      CK_RING = 3'd6,
      CK_EXT  = 3'd7
   } clk_src_e;

   typedef enum logic [SRC_W-1:0] {
      GT_ON    = 3'd0,
      GT_OFF   = 3'd1,
      GT_EXT   = 3'd2,
      GT_NBINV = 3'd3
   } gate_src_e;

   function automatic logic [CH_W-1:0] cfg_chan(input logic [CFG_W-1:0] b);
      return b[CH_LSB +: CH_W];
   endfunction

   function automatic logic [SRC_W-1:0] cfg_src(input logic [CFG_W-1:0] b);
      return b[SRC_W-1:0];
   endfunction

endpackage

// File: rtl/ctr_route_prescaler.sv
module ctr_route_prescaler #(
   parameter int DIV    = 10,
   parameter int STAGES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_tick,
   output logic [STAGES-1:0] div_pulse
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("ctr_route_prescaler: DIV must be at least 2");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("ctr_route_prescaler: STAGES must be at least 1");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic          adv;
      logic [CW-1:0] cnt;

      if (s == 0) begin : g_first
         assign adv = base_tick;
      end else begin : g_chain
         assign adv = div_pulse[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (adv) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
      end

      assign div_pulse[s] = adv && (cnt == LAST);

      // R2
      single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         div_pulse[s] |=> !div_pulse[s]);
   end

   // R2
   pulse_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|div_pulse) |-> base_tick);

endmodule

// File: rtl/ctr_route_cfg.sv
module ctr_route_cfg
   import ctr_route_pkg::*;
#(
   parameter int              N_CH     = 3,
   parameter bit              IS_CLK   = 1'b1,
   parameter logic [SRC_W-1:0] RST_CODE = 3'd1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [CFG_W-1:0]           cfg_byte,
   output logic [N_CH-1:0][SRC_W-1:0] sel
);
   logic [CH_W-1:0]  ch;
   logic [SRC_W-1:0] src;
   logic             code_ok;
   logic             ch_ok;
   logic             hit;
   logic             unused_hi;

   assign ch        = cfg_chan(cfg_byte);
   assign src       = cfg_src(cfg_byte);
   assign unused_hi = ^cfg_byte[CFG_W-1:CH_LSB+CH_W];
   assign ch_ok     = int'(ch) < N_CH;

   if (IS_CLK) begin : g_clk_codes
      assign code_ok = (src != CK_RSVD);
   end else begin : g_gate_codes
      assign code_ok = (src <= GT_NBINV);
   end

   assign hit = we && code_ok && ch_ok;

   for (genvar i = 0; i < N_CH; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel[i] <= RST_CODE;
         end else if (hit && (ch == CH_W'(i))) begin
            sel[i] <= src;
         end
      end

      // R3
      write_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && code_ok && ch == CH_W'(i)) |=> (sel[i] == $past(src)));
   end

   // R7
   noop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !(code_ok && ch_ok)) |=> $stable(sel));

endmodule

// File: rtl/ctr_clkgate_router.sv
module ctr_clkgate_router
   import ctr_route_pkg::*;
#(
   parameter int N_CH = 3,
   parameter int DIV  = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            base_tick,
   input  logic            ext_clk_pulse,
   input  logic            ext_gate,
   input  logic            clk_cfg_we,
   input  logic [7:0]      clk_cfg_byte,
   input  logic            gate_cfg_we,
   input  logic [7:0]      gate_cfg_byte,
   input  logic [N_CH-1:0] ctr_out,
   output logic [N_CH-1:0] ctr_clk_en,
   output logic [N_CH-1:0] ctr_gate
);
   if (N_CH < 2 || N_CH > 3) begin : g_bad_nch
      $error("ctr_clkgate_router: N_CH must be 2 or 3");
   end

   logic [NUM_DIV-1:0]          div_pulse;
   logic [N_CH-1:0][SRC_W-1:0]  clk_sel;
   logic [N_CH-1:0][SRC_W-1:0]  gate_sel;
   logic [N_CH-1:0]             out_prev;
   logic [N_CH-1:0]             out_rise;

   ctr_route_prescaler #(.DIV(DIV), .STAGES(NUM_DIV)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .base_tick(base_tick),
      .div_pulse(div_pulse)
   );

   ctr_route_cfg #(.N_CH(N_CH), .IS_CLK(1'b1), .RST_CODE(CK_BASE)) u_clk_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (clk_cfg_we),
      .cfg_byte(clk_cfg_byte),
      .sel     (clk_sel)
   );

   ctr_route_cfg #(.N_CH(N_CH), .IS_CLK(1'b0), .RST_CODE(GT_ON)) u_gate_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (gate_cfg_we),
      .cfg_byte(gate_cfg_byte),
      .sel     (gate_sel)
   );

   // previous sample of counter outputs for rising-edge clocking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_prev <= '0;
      else        out_prev <= ctr_out;
   end
   assign out_rise = ctr_out & ~out_prev;

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      localparam int NB_CLK  = (i + N_CH - 1) % N_CH;
      localparam int NB_GATE = (i + 1) % N_CH;

      always_comb begin
         case (clk_src_e'(clk_sel[i]))
            CK_BASE: ctr_clk_en[i] = base_tick;
            CK_DIV1: ctr_clk_en[i] = div_pulse[0];
            CK_DIV2: ctr_clk_en[i] = div_pulse[1];
            CK_DIV3: ctr_clk_en[i] = div_pulse[2];
            CK_DIV4: ctr_clk_en[i] = div_pulse[3];
            CK_RING: ctr_clk_en[i] = out_rise[NB_CLK];
            CK_EXT:  ctr_clk_en[i] = ext_clk_pulse;
            default: ctr_clk_en[i] = 1'b0;
         endcase
      end

      always_comb begin
         case (gate_src_e'(gate_sel[i]))
            GT_ON:    ctr_gate[i] = 1'b1;
            GT_OFF:   ctr_gate[i] = 1'b0;
            GT_EXT:   ctr_gate[i] = ext_gate;
            GT_NBINV: ctr_gate[i] = ~ctr_out[NB_GATE];
            default:  ctr_gate[i] = 1'b1;
         endcase
      end

      // R4
      base_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clk_sel[i] == CK_BASE) |-> (ctr_clk_en[i] == base_tick));

      // R6
      gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (gate_sel[i] == GT_OFF) |-> !ctr_gate[i]);
   end

endmodule

// File: tb/ctr_clkgate_router_test.sv
module ctr_clkgate_router_test;
   localparam int CLK_PERIOD = 10;
   localparam int N = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       base_tick = 1'b0;
   logic       ext_clk_pulse = 1'b0;
   logic       ext_gate = 1'b0;
   logic       clk_cfg_we = 1'b0;
   logic [7:0] clk_cfg_byte = '0;
   logic       gate_cfg_we = 1'b0;
   logic [7:0] gate_cfg_byte = '0;
   logic [2:0] ctr_out = '0;
   logic [2:0] ctr_clk_en;
   logic [2:0] ctr_gate;

   ctr_clkgate_router uut (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
      .ext_clk_pulse(ext_clk_pulse), .ext_gate(ext_gate),
      .clk_cfg_we(clk_cfg_we), .clk_cfg_byte(clk_cfg_byte),
      .gate_cfg_we(gate_cfg_we), .gate_cfg_byte(gate_cfg_byte),
      .ctr_out(ctr_out), .ctr_clk_en(ctr_clk_en), .ctr_gate(ctr_gate)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      string      req;
      logic [2:0] exp_en;
      logic [2:0] exp_gate;
      bit         use_gate;
   } item_t;

   item_t sb_q[$];
   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // reference state, built from the requirements
   int unsigned ticks = 0;
   logic [2:0] out_prev = '0;
   int csel[N] = '{1, 1, 1};
   int gsel[N] = '{0, 0, 0};
   bit pend_c = 0, pend_g = 0;
   logic [7:0] pend_cb, pend_gb;

   always @(posedge clk) begin
      if (rst_n && base_tick) ticks <= ticks + 1;
      out_prev <= rst_n ? ctr_out : 3'b000;
   end

   function automatic logic [7:0] cb(logic [2:0] hi, int ch, int code);
      return {hi, 2'(ch), 3'(code)};
   endfunction

   function automatic logic pulse_at(int unsigned d);
      return base_tick && (((ticks + 1) % d) == 0);
   endfunction

   function automatic logic [2:0] model_en();
      logic [2:0] r;
      for (int i = 0; i < N; i++) begin
         case (csel[i])
            1: r[i] = base_tick;
            2: r[i] = pulse_at(10);
            3: r[i] = pulse_at(100);
            4: r[i] = pulse_at(1000);
            5: r[i] = pulse_at(10000);
            6: r[i] = ctr_out[(i+2)%N] & ~out_prev[(i+2)%N];
            7: r[i] = ext_clk_pulse;
            default: r[i] = 1'b0;
         endcase
      end
      return r;
   endfunction

   function automatic logic [2:0] model_gate();
      logic [2:0] r;
      for (int i = 0; i < N; i++) begin
         case (gsel[i])
            0: r[i] = 1'b1;
            1: r[i] = 1'b0;
            2: r[i] = ext_gate;
            default: r[i] = ~ctr_out[(i+1)%N];
         endcase
      end
      return r;
   endfunction

   task automatic expect_now(string req, bit use_gate);
      item_t it;
      it.req = req;
      it.exp_en = model_en();
      it.exp_gate = model_gate();
      it.use_gate = use_gate;
      sb_q.push_back(it);
   endtask

   task automatic wr_clk(logic [7:0] b);
      clk_cfg_we = 1'b1; clk_cfg_byte = b; pend_c = 1; pend_cb = b;
   endtask

   task automatic wr_gate(logic [7:0] b);
      gate_cfg_we = 1'b1; gate_cfg_byte = b; pend_g = 1; pend_gb = b;
   endtask

   task automatic advance();
      @(posedge clk);
      #1;
      if (pend_c && pend_cb[4:3] != 2'd3 && pend_cb[2:0] != 3'd0)
         csel[pend_cb[4:3]] = int'(pend_cb[2:0]);
      if (pend_g && pend_gb[4:3] != 2'd3 && pend_gb[2:0] <= 3'd3)
         gsel[pend_gb[4:3]] = int'(pend_gb[2:0]);
      pend_c = 0; pend_g = 0;
      clk_cfg_we = 1'b0; gate_cfg_we = 1'b0;
   endtask

   // monitor: pops expectations and compares with the outputs
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (ctr_clk_en !== it.exp_en ||
             (it.use_gate && ctr_gate !== it.exp_gate)) begin
            failures++;
            $display("FAIL %s: clk_en=%b gate=%b expected clk_en=%b gate=%b",
                     it.req, ctr_clk_en, ctr_gate, it.exp_en, it.exp_gate);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         failures++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      base_tick = 1'b1;
      expect_now("R1 reset state", 1);
      advance();
      base_tick = 1'b0;
      expect_now("R1 base clock idle", 1);
      advance();
      base_tick = 1'b1;

      // R8: clock and gate writes together on channel 0
      wr_clk(cb(3'b000, 0, 2));
      wr_gate(cb(3'b000, 0, 1));
      expect_now("R8 before write", 1);
      advance();
      expect_now("R8 both applied", 1);
      // R3: upper bits ignored
      wr_clk(cb(3'b111, 1, 3));
      advance();
      expect_now("R3 high bits ignored", 1);
      wr_clk(cb(3'b000, 2, 5));
      advance();

      // R2: prescaler chain through the 1 kHz stage
      for (int k = 0; k < 10100; k++) begin
         expect_now("R2 divider chain", 1);
         advance();
      end
      wr_clk(cb(3'b000, 2, 4));
      advance();
      for (int k = 0; k < 1100; k++) begin
         expect_now("R2 10kHz stage", 1);
         advance();
      end

      // R7: no-op writes
      wr_clk(cb(3'b000, 0, 0));
      wr_gate(cb(3'b000, 1, 5));
      expect_now("R7 noop issued", 1);
      advance();
      wr_clk(cb(3'b000, 3, 7));
      wr_gate(cb(3'b000, 3, 1));
      expect_now("R7 noop issued", 1);
      advance();
      for (int k = 0; k < 30; k++) begin
         expect_now("R7 selections kept", 1);
         advance();
      end

      // R4: external clock pulse
      wr_clk(cb(3'b000, 1, 7));
      advance();
      for (int k = 0; k < 8; k++) begin
         ext_clk_pulse = k[0];
         expect_now("R4 external clock", 1);
         advance();
      end
      ext_clk_pulse = 1'b0;

      // R5: neighbour ring clocking
      for (int c = 0; c < N; c++) begin
         wr_clk(cb(3'b000, c, 6));
         advance();
      end
      begin
         logic [2:0] pat [10] = '{3'b000, 3'b001, 3'b001, 3'b101, 3'b111,
                                  3'b011, 3'b010, 3'b110, 3'b000, 3'b100};
         for (int k = 0; k < 10; k++) begin
            ctr_out = pat[k];
            expect_now("R5 ring edge", 1);
            advance();
         end
      end

      // R6: inverted neighbour gates
      for (int c = 0; c < N; c++) begin
         wr_gate(cb(3'b000, c, 3));
         advance();
      end
      for (int k = 0; k < 8; k++) begin
         ctr_out = 3'(k);
         expect_now("R6 inverted neighbour gate", 1);
         advance();
      end
      wr_gate(cb(3'b000, 1, 2));
      advance();
      for (int k = 0; k < 6; k++) begin
         ext_gate = k[0];
         expect_now("R6 external gate", 1);
         advance();
      end
      wr_gate(cb(3'b000, 1, 0));
      advance();
      expect_now("R6 gate held on", 1);

      // R8: same channel, both writes
      wr_clk(cb(3'b000, 2, 1));
      wr_gate(cb(3'b000, 2, 1));
      advance();
      expect_now("R8 same channel", 1);
      advance();
      expect_now("R8 same channel held", 1);
      advance();
      advance();

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule